// File: doc/BRIEF.md
# Universal Shift Register with JK Entry Stage

A clocked register, `WIDTH` bits wide (4 by default), with two synchronous modes chosen by an active-low mode input. With `load_ni` low, every bit takes the matching parallel input on the rising clock edge. With `load_ni` high, the contents move one position toward the highest index. Bit 0 then takes a value decided by a J input and an active-low K input, so the entry stage can set, clear, toggle or hold.

Tying `j_i` and `kn_i` together turns the entry stage into a plain serial D input. Serial-to-parallel, parallel-to-serial and simple counting uses follow from that. An active-low asynchronous reset clears the register whenever it is low. A separate output always gives the inverse of the highest bit.

Top module: `uni_shift_reg`

## Requirements
- R1: While `rst_ni` is low, `q_o` is all zeros. The clear takes effect as soon as `rst_ni` falls, without waiting for a clock edge, and it overrides every other input.
- R2: `q_last_n_o` is always the inverse of `q_o[WIDTH-1]`, so it reads 1 while reset is held.
- R3: On a rising edge with `load_ni` = 0, `q_o` takes the value of `par_i`, bit for bit. `j_i` and `kn_i` have no effect in this mode.
- R4: On a rising edge with `load_ni` = 1, every bit `q_o[i]` with i >= 1 takes the previous value of `q_o[i-1]`. `par_i` has no effect in this mode.
- R5: In shift mode with `j_i` = 1 and `kn_i` = 1, `q_o[0]` becomes 1.
- R6: In shift mode with `j_i` = 0 and `kn_i` = 0, `q_o[0]` becomes 0.
- R7: In shift mode with `j_i` = 1 and `kn_i` = 0, `q_o[0]` becomes the inverse of its previous value.
- R8: In shift mode with `j_i` = 0 and `kn_i` = 1, `q_o[0]` keeps its previous value.
- R9: With `j_i` and `kn_i` driven to the same level, `q_o[0]` takes that level on each shift edge, acting as a serial data input.
- R10: If `rst_ni` is released between clock edges, the register stays cleared until the next rising edge. That edge is then handled as a normal load or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all transfers happen on its rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Mode select: 0 = parallel load, 1 = shift toward the highest index |
| j_i | input | 1 | J input of the entry stage |
| kn_i | input | 1 | K input of the entry stage, active low |
| par_i | input | WIDTH | Parallel data |
| q_o | output | WIDTH | Register contents |
| q_last_n_o | output | 1 | Inverse of `q_o[WIDTH-1]` |

## Verification
The hardest case to reach from the ports is reset moving in the middle of a clock period. Reset is dropped halfway between two edges while the register holds all ones. The bench confirms that the outputs clear before the next edge and stay clear across an edge on which a load is requested. Reset is then released mid-period with a load pending, and the bench confirms that nothing changes until the following rising edge, which performs that load. The four J/K combinations are chained in a vector table so that toggle and hold are each seen starting from both 0 and 1.

// File: rtl/usr_pkg.sv
package usr_pkg;

  // Encoding equals {j, kn}
  typedef enum logic [1:0] {
    FS_CLR  = 2'b00,
    FS_HOLD = 2'b01,
    FS_TGL  = 2'b10,
    FS_SET  = 2'b11
  } fs_op_e;

  function automatic logic fs_next(fs_op_e op, logic cur);
    logic nxt;
    unique case (op)
      FS_CLR:  nxt = 1'b0;
      FS_SET:  nxt = 1'b1;
      FS_TGL:  nxt = ~cur;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/usr_first_stage.sv
module usr_first_stage
  import usr_pkg::*;
(
  input  logic load_ni,
  input  logic j_i,
  input  logic kn_i,
  input  logic par_i,
  input  logic cur_i,
  output logic nxt_o
);

  fs_op_e op;

  always_comb begin
    op    = fs_op_e'({j_i, kn_i});
    nxt_o = load_ni ? fs_next(op, cur_i) : par_i;
  end

endmodule

// File: rtl/usr_stage_mux.sv
module usr_stage_mux #(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned UPPER = WIDTH - 1
) (
  input  logic             load_ni,
  input  logic [UPPER-1:0] par_hi_i,  // par bits 1..WIDTH-1
  input  logic [UPPER-1:0] q_lo_i,    // q bits 0..WIDTH-2
  output logic [UPPER-1:0] nxt_hi_o   // next bits 1..WIDTH-1
);

  for (genvar i = 0; i < UPPER; i++) begin : g_stage
    assign nxt_hi_o[i] = load_ni ? q_lo_i[i] : par_hi_i[i];
  end

endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             j_i,
  input  logic             kn_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o,
  output logic             q_last_n_o
);

  localparam int unsigned MSB = WIDTH - 1;

  if (WIDTH < 2) begin : g_bad_width
    initial $error("uni_shift_reg: WIDTH must be at least 2");
  end

  logic [MSB:0] q_q;
  logic [MSB:0] q_d;

  usr_first_stage u_first (
    .load_ni (load_ni),
    .j_i     (j_i),
    .kn_i    (kn_i),
    .par_i   (par_i[0]),
    .cur_i   (q_q[0]),
    .nxt_o   (q_d[0])
  );

  usr_stage_mux #(.WIDTH(WIDTH)) u_mux (
    .load_ni  (load_ni),
    .par_hi_i (par_i[MSB:1]),
    .q_lo_i   (q_q[MSB-1:0]),
    .nxt_hi_o (q_d[MSB:1])
  );

  usr_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (q_d),
    .q_o    (q_q)
  );

  assign q_o        = q_q;
  assign q_last_n_o = ~q_q[MSB];

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_q == $past(par_i));

  assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> q_q[MSB:1] == $past(q_q[MSB-1:0]));

  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && j_i && kn_i) |=> q_q[0]);

  assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !j_i && !kn_i) |=> !q_q[0]);

  assert_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && j_i && !kn_i) |=> q_q[0] != $past(q_q[0]));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !j_i && kn_i) |=> $stable(q_q[0]));

endmodule

// File: tb/uni_shift_reg_bench.sv
module uni_shift_reg_bench;

  localparam int W = 4;
  localparam int NVEC = 15;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_ni = 1'b1;
  logic         j_i = 1'b0;
  logic         kn_i = 1'b1;
  logic [W-1:0] par_i = '0;
  logic [W-1:0] q_o;
  logic         q_last_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  uni_shift_reg #(.WIDTH(W)) u_uni_shift_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_ni    (load_ni),
    .j_i        (j_i),
    .kn_i       (kn_i),
    .par_i      (par_i),
    .q_o        (q_o),
    .q_last_n_o (q_last_n_o)
  );

  // {load_n, j, kn, par[3:0], expected q[3:0]}, starting from q = 0000
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0_0_0_1010_1010,  // load (R3)
    11'b1_1_1_1111_0101,  // set (R5), par ignored
    11'b1_1_0_0000_1010,  // toggle 1->0 (R7)
    11'b1_0_1_0000_0100,  // hold 0 (R8)
    11'b1_1_0_0000_1001,  // toggle 0->1 (R7)
    11'b1_0_1_1111_0011,  // hold 1 (R8)
    11'b1_0_0_0000_0110,  // clear (R6)
    11'b0_0_0_1111_1111,  // load (R3)
    11'b1_0_0_0000_1110,  // clear (R6)
    11'b1_1_1_0000_1101,  // set (R5)
    11'b0_1_0_0000_0000,  // load, J/K ignored (R3)
    11'b1_1_1_0000_0001,  // D-style 1 (R9)
    11'b1_0_0_0000_0010,  // D-style 0 (R9)
    11'b1_0_1_0000_0100,  // hold (R8)
    11'b1_1_0_0000_1001   // toggle (R7)
  };

  function automatic string mode_req(logic ld_n, logic j, logic kn);
    if (!ld_n)          return "R3";
    if (j && kn)        return "R5/R9";
    if (!j && !kn)      return "R6/R9";
    if (j && !kn)       return "R7";
    return "R8";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_comp(string req);
    check(req, {31'd0, q_last_n_o}, {31'd0, ~q_o[W-1]});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] prev;

    // Reset state
    repeat (3) @(posedge clk_i);
    #2;
    check("R1 reset state", {28'd0, q_o}, 32'd0);
    check("R2 comp high in reset", {31'd0, q_last_n_o}, 32'd1);

    @(negedge clk_i);
    rst_ni = 1'b1;

    // Vector table
    prev = '0;
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk_i);
      {load_ni, j_i, kn_i, par_i} = VEC[v][10:4];
      @(posedge clk_i);
      #2;
      check(mode_req(load_ni, j_i, kn_i), {28'd0, q_o}, {28'd0, VEC[v][3:0]});
      if (load_ni)
        check("R4 upper stages shift", {29'd0, q_o[W-1:1]}, {29'd0, prev[W-2:0]});
      check_comp("R2");
      prev = VEC[v][3:0];
    end

    // Mid-period reset while full of ones
    @(negedge clk_i);
    load_ni = 1'b0; par_i = 4'b1111;
    @(posedge clk_i);
    #2;
    check("R3 preload ones", {28'd0, q_o}, 32'hF);
    #3;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear mid-period", {28'd0, q_o}, 32'd0);
    check("R2 comp high after async clear", {31'd0, q_last_n_o}, 32'd1);
    @(posedge clk_i);
    #2;
    check("R1 reset overrides load edge", {28'd0, q_o}, 32'd0);

    // Mid-period release with a load pending
    par_i = 4'b0110;
    #3;
    rst_ni = 1'b1;
    #4;
    check("R10 no change before edge", {28'd0, q_o}, 32'd0);
    @(posedge clk_i);
    #2;
    check("R10 first edge loads", {28'd0, q_o}, 32'h6);
    check_comp("R2 after release");

    // Shift mode ignores par, serial D stream
    @(negedge clk_i);
    load_ni = 1'b1; j_i = 1'b1; kn_i = 1'b1; par_i = 4'b0000;
    @(posedge clk_i);
    #2;
    check("R4 par ignored in shift", {28'd0, q_o}, 32'hD);
    check_comp("R2 msb set");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule